// File: doc/BRIEF.md
# SPI bus monitor

The block listens to a four-wire SPI bus without driving any of its lines. The system clock must run well above the serial clock. The block resynchronises the serial clock, both data lines and the chip-select. It picks the capture edge from the programmed clock polarity and phase, and it shifts the host-to-device and device-to-host lines into two separate registers on that edge. When the programmed number of bits has been gathered, it emits one record. The record holds both data words, the span of the word in system clocks from its first to its last capture edge, and a flag set if chip-select was inactive at any capture edge of that word.

Chip-select can be turned off by a configuration input. While it is enabled, every change of its level produces a separate event that carries the old and the new level, and the change restarts word framing. Both outputs are single-cycle valid pulses. A downstream collector may use the duration to derive the bit rate of the bus.

Top module: `spi_sniffer`

## Requirements
- R1: With cpol_i/cpha_i = 0/0 or 1/1 the lines are captured on the rising serial clock edge. With 0/1 or 1/0 they are captured on the falling edge. Edges of the other direction have no effect.
- R2: On each capture edge, mosi_i and miso_i are both taken. A finished word presents both values together in word_mosi_o and word_miso_o with a one-cycle word_valid_o.
- R3: With lsb_first_i = 0, the k-th captured bit (counting from 0) lands at bit len-1-k of the word. With lsb_first_i = 1, it lands at bit k.
- R4: The word length word_len_i takes values 1 to 32, and 0 or any larger value means 32. A word completes on the capture edge that brings the bit count to that length. Framing then restarts, so back-to-back words need no chip-select toggle.
- R5: The chip-select is active low when cs_act_high_i = 0 and active high when it is 1. While cs_en_i = 1, every change of the cs_i level gives a one-cycle cs_evt_valid_o, with cs_evt_old_o and cs_evt_new_o holding the levels before and after the change.
- R6: A chip-select change discards any partial word. A capture edge seen in the same cycle as the change counts as the first bit of the new word.
- R7: word_err_o is 1 when chip-select was inactive at any capture edge of that word. It starts from 0 for every new word.
- R8: word_dur_o equals the number of system clocks from the first to the last capture edge of the word, counting both ends. A one-bit word gives 1. The count saturates at its all-ones value.
- R9: With cs_en_i = 0, no chip-select event is produced, cs_i does not affect framing and never sets word_err_o.
- R10: When a chip-select event and a finished word fall in the same cycle, the event is presented first and the word record follows one cycle later.
- R11: After reset, both valid outputs are 0, and the idle levels on the lines at reset release give no event and no word. A change on an input becomes visible on the outputs three system clocks after the edge that samples it.
- R12: Record bits at and above the word length are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sck_i | input | 1 | Serial clock line |
| mosi_i | input | 1 | Host-to-device data line |
| miso_i | input | 1 | Device-to-host data line |
| cs_i | input | 1 | Chip-select line |
| cpol_i | input | 1 | Clock polarity |
| cpha_i | input | 1 | Clock phase |
| lsb_first_i | input | 1 | 1: first bit is bit 0 |
| word_len_i | input | 6 | Bits per word, 0 means 32 |
| cs_act_high_i | input | 1 | 1: chip-select active high |
| cs_en_i | input | 1 | 1: chip-select is used |
| word_valid_o | output | 1 | Record valid pulse |
| word_mosi_o | output | 32 | Host-to-device word |
| word_miso_o | output | 32 | Device-to-host word |
| word_dur_o | output | 32 | Word span in system clocks |
| word_err_o | output | 1 | Chip-select was inactive inside the word |
| cs_evt_valid_o | output | 1 | Chip-select event pulse |
| cs_evt_old_o | output | 1 | Chip-select level before the change |
| cs_evt_new_o | output | 1 | Chip-select level after the change |

## Verification
Word records and chip-select events are due three system clocks after the edge that samples the causing input: two synchroniser stages plus the output register. A word that finishes together with a chip-select change is due four clocks after that edge. The bench drives inputs on the falling clock edge and logs every pulse on the falling edge with its cycle number. The latency checks compare these timestamps against the drive cycle plus three or four. Other checks read the last logged record once a settling window well past that latency has elapsed.

// File: rtl/spi_mon_pkg.sv
package spi_mon_pkg;
  // capture on the rising edge for modes 0 and 3
  function automatic logic cap_on_rise(input logic cpol, input logic cpha);
    return ~(cpol ^ cpha);
  endfunction
endpackage

// File: rtl/spi_mon_sync.sv
module spi_mon_sync #(
  parameter int unsigned N      = 4,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] d_i,
  output logic [N-1:0] q_o
);
  for (genvar i = 0; i < N; i++) begin : g_line
    logic [STAGES-1:0] ff_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) ff_q <= '0;
      else         ff_q <= {ff_q[STAGES-2:0], d_i[i]};
    end
    assign q_o[i] = ff_q[STAGES-1];
  end
endmodule

// File: rtl/spi_mon_edge.sv
module spi_mon_edge #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sck_i,
  input  logic cs_i,
  input  logic cpol_i,
  input  logic cpha_i,
  input  logic cs_en_i,
  output logic cap_o,
  output logic cs_chg_o,
  output logic cs_old_o,
  output logic cs_new_o
);
  import spi_mon_pkg::*;
  localparam int unsigned PRIME = STAGES + 1;
  localparam int unsigned PW    = $clog2(PRIME + 1);

  logic [PW-1:0] prime_q;
  logic          primed;
  logic          sck_q, cs_q;

  assign primed = (prime_q == PW'(PRIME));

  // history tracks the lines even before priming, so no spurious edge later
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prime_q <= '0;
      sck_q   <= 1'b0;
      cs_q    <= 1'b0;
    end else begin
      if (!primed) prime_q <= prime_q + 1'b1;
      sck_q <= sck_i;
      cs_q  <= cs_i;
    end
  end

  assign cap_o    = primed && (sck_i != sck_q) && (sck_i == cap_on_rise(cpol_i, cpha_i));
  assign cs_chg_o = primed && cs_en_i && (cs_i != cs_q);
  assign cs_old_o = cs_q;
  assign cs_new_o = cs_i;
endmodule

// File: rtl/spi_mon_frame.sv
module spi_mon_frame #(
  parameter int unsigned MAX_W = 32,
  parameter int unsigned DUR_W = 32,
  parameter int unsigned LEN_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cap_i,
  input  logic             cs_chg_i,
  input  logic             mosi_i,
  input  logic             miso_i,
  input  logic             cs_lvl_i,
  input  logic             cs_en_i,
  input  logic             cs_act_high_i,
  input  logic             lsb_first_i,
  input  logic [LEN_W-1:0] word_len_i,
  output logic             done_o,
  output logic [MAX_W-1:0] mosi_o,
  output logic [MAX_W-1:0] miso_o,
  output logic [DUR_W-1:0] dur_o,
  output logic             err_o
);
  logic [LEN_W-1:0] cnt_q, cnt_d, b_cnt, eff_len, pos;
  logic [MAX_W-1:0] mo_q, mo_d, b_mo, mi_q, mi_d, b_mi;
  logic [DUR_W-1:0] dur_q, dur_d, b_dur, dur_cur;
  logic             err_q, err_d, b_err, deass;

  function automatic logic [DUR_W-1:0] sat_inc(input logic [DUR_W-1:0] v);
    return (v == '1) ? v : v + 1'b1;
  endfunction

  always_comb begin
    eff_len = (word_len_i == '0 || word_len_i > LEN_W'(MAX_W)) ? LEN_W'(MAX_W) : word_len_i;
    // chip-select change restarts framing before this cycle's edge is taken
    b_cnt = cs_chg_i ? '0   : cnt_q;
    b_mo  = cs_chg_i ? '0   : mo_q;
    b_mi  = cs_chg_i ? '0   : mi_q;
    b_err = cs_chg_i ? 1'b0 : err_q;
    b_dur = cs_chg_i ? '0   : dur_q;
    deass = cs_en_i && (cs_lvl_i != cs_act_high_i);
    pos   = lsb_first_i ? b_cnt : LEN_W'(eff_len - 1'b1 - b_cnt);

    cnt_d   = b_cnt;
    mo_d    = b_mo;
    mi_d    = b_mi;
    err_d   = b_err;
    dur_d   = (b_cnt != '0) ? sat_inc(b_dur) : b_dur;
    dur_cur = dur_d;
    done_o  = 1'b0;

    if (cap_i) begin
      mo_d    = b_mo | (MAX_W'(mosi_i) << pos);
      mi_d    = b_mi | (MAX_W'(miso_i) << pos);
      err_d   = b_err | deass;
      dur_cur = (b_cnt == '0) ? DUR_W'(1) : sat_inc(b_dur);
      dur_d   = dur_cur;
      cnt_d   = LEN_W'(b_cnt + 1'b1);
      if (cnt_d == eff_len) done_o = 1'b1;
    end

    mosi_o = mo_d;
    miso_o = mi_d;
    dur_o  = dur_cur;
    err_o  = err_d;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      mo_q  <= '0;
      mi_q  <= '0;
      dur_q <= '0;
      err_q <= 1'b0;
    end else if (done_o) begin
      cnt_q <= '0;
      mo_q  <= '0;
      mi_q  <= '0;
      dur_q <= '0;
      err_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      mo_q  <= mo_d;
      mi_q  <= mi_d;
      dur_q <= dur_d;
      err_q <= err_d;
    end
  end
endmodule

// File: rtl/spi_mon_out.sv
module spi_mon_out #(
  parameter int unsigned MAX_W = 32,
  parameter int unsigned DUR_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             done_i,
  input  logic [MAX_W-1:0] mosi_i,
  input  logic [MAX_W-1:0] miso_i,
  input  logic [DUR_W-1:0] dur_i,
  input  logic             err_i,
  input  logic             cs_chg_i,
  input  logic             cs_old_i,
  input  logic             cs_new_i,
  output logic             word_valid_o,
  output logic [MAX_W-1:0] word_mosi_o,
  output logic [MAX_W-1:0] word_miso_o,
  output logic [DUR_W-1:0] word_dur_o,
  output logic             word_err_o,
  output logic             cs_evt_valid_o,
  output logic             cs_evt_old_o,
  output logic             cs_evt_new_o
);
  logic pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q         <= 1'b0;
      word_valid_o   <= 1'b0;
      word_mosi_o    <= '0;
      word_miso_o    <= '0;
      word_dur_o     <= '0;
      word_err_o     <= 1'b0;
      cs_evt_valid_o <= 1'b0;
      cs_evt_old_o   <= 1'b0;
      cs_evt_new_o   <= 1'b0;
    end else begin
      // word finishing with a chip-select change waits one cycle
      pend_q         <= done_i & cs_chg_i;
      word_valid_o   <= (done_i & ~cs_chg_i) | pend_q;
      cs_evt_valid_o <= cs_chg_i;
      if (done_i) begin
        word_mosi_o <= mosi_i;
        word_miso_o <= miso_i;
        word_dur_o  <= dur_i;
        word_err_o  <= err_i;
      end
      if (cs_chg_i) begin
        cs_evt_old_o <= cs_old_i;
        cs_evt_new_o <= cs_new_i;
      end
    end
  end
endmodule

// File: rtl/spi_sniffer.sv
module spi_sniffer #(
  parameter int unsigned MAX_W  = 32,
  parameter int unsigned DUR_W  = 32,
  parameter int unsigned STAGES = 2,
  localparam int unsigned LEN_W = $clog2(MAX_W + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sck_i,
  input  logic             mosi_i,
  input  logic             miso_i,
  input  logic             cs_i,
  input  logic             cpol_i,
  input  logic             cpha_i,
  input  logic             lsb_first_i,
  input  logic [LEN_W-1:0] word_len_i,
  input  logic             cs_act_high_i,
  input  logic             cs_en_i,
  output logic             word_valid_o,
  output logic [MAX_W-1:0] word_mosi_o,
  output logic [MAX_W-1:0] word_miso_o,
  output logic [DUR_W-1:0] word_dur_o,
  output logic             word_err_o,
  output logic             cs_evt_valid_o,
  output logic             cs_evt_old_o,
  output logic             cs_evt_new_o
);
  logic [3:0] line_s;
  logic cap, cs_chg, cs_old, cs_new, done, err;
  logic [MAX_W-1:0] mo, mi;
  logic [DUR_W-1:0] dur;

  spi_mon_sync #(.N(4), .STAGES(STAGES)) u_sync (
    .clk_i, .rst_ni,
    .d_i({cs_i, miso_i, mosi_i, sck_i}),
    .q_o(line_s)
  );

  spi_mon_edge #(.STAGES(STAGES)) u_edge (
    .clk_i, .rst_ni,
    .sck_i(line_s[0]), .cs_i(line_s[3]),
    .cpol_i, .cpha_i, .cs_en_i,
    .cap_o(cap), .cs_chg_o(cs_chg), .cs_old_o(cs_old), .cs_new_o(cs_new)
  );

  spi_mon_frame #(.MAX_W(MAX_W), .DUR_W(DUR_W), .LEN_W(LEN_W)) u_frame (
    .clk_i, .rst_ni,
    .cap_i(cap), .cs_chg_i(cs_chg),
    .mosi_i(line_s[1]), .miso_i(line_s[2]), .cs_lvl_i(line_s[3]),
    .cs_en_i, .cs_act_high_i, .lsb_first_i, .word_len_i,
    .done_o(done), .mosi_o(mo), .miso_o(mi), .dur_o(dur), .err_o(err)
  );

  spi_mon_out #(.MAX_W(MAX_W), .DUR_W(DUR_W)) u_out (
    .clk_i, .rst_ni,
    .done_i(done), .mosi_i(mo), .miso_i(mi), .dur_i(dur), .err_i(err),
    .cs_chg_i(cs_chg), .cs_old_i(cs_old), .cs_new_i(cs_new),
    .word_valid_o, .word_mosi_o, .word_miso_o, .word_dur_o, .word_err_o,
    .cs_evt_valid_o, .cs_evt_old_o, .cs_evt_new_o
  );
endmodule

// File: rtl/spi_mon_chk.sv
module spi_mon_chk #(
  parameter int unsigned MAX_W = 32,
  parameter int unsigned DUR_W = 32,
  parameter int unsigned LEN_W = 6
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cs_en_i,
  input logic [LEN_W-1:0] word_len_i,
  input logic             word_valid_o,
  input logic [MAX_W-1:0] word_mosi_o,
  input logic [MAX_W-1:0] word_miso_o,
  input logic [DUR_W-1:0] word_dur_o,
  input logic             cs_evt_valid_o,
  input logic             cs_evt_old_o,
  input logic             cs_evt_new_o
);
  logic [LEN_W-1:0] eff;
  logic [MAX_W-1:0] mask;

  always_comb begin
    eff = (word_len_i == '0 || word_len_i > LEN_W'(MAX_W)) ? LEN_W'(MAX_W) : word_len_i;
    for (int i = 0; i < MAX_W; i++) mask[i] = (i < int'(eff));
  end

  // R5
  cs_evt_levels_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_evt_valid_o |-> (cs_evt_old_o != cs_evt_new_o));

  // R9
  cs_off_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_evt_valid_o |-> $past(cs_en_i));

  // R8
  dur_nonzero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_valid_o |-> (word_dur_o != '0));

  // R10
  word_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_valid_o |=> !word_valid_o);

  // R12
  word_width_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_valid_o |-> (((word_mosi_o & ~mask) == '0) && ((word_miso_o & ~mask) == '0)));
endmodule

bind spi_sniffer spi_mon_chk #(.MAX_W(MAX_W), .DUR_W(DUR_W), .LEN_W(LEN_W)) u_chk (
  .clk_i, .rst_ni, .cs_en_i, .word_len_i,
  .word_valid_o, .word_mosi_o, .word_miso_o, .word_dur_o,
  .cs_evt_valid_o, .cs_evt_old_o, .cs_evt_new_o
);

// File: tb/sim_spi_sniffer.sv
module sim_spi_sniffer;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sck = 1'b0, mosi = 1'b0, miso = 1'b0, cs = 1'b1;
  logic cpol = 1'b0, cpha = 1'b0, lsb = 1'b0, cs_ah = 1'b0, cs_en = 1'b1;
  logic [5:0] wlen = 6'd8;
  logic word_valid, word_err, evt_valid, evt_old, evt_new;
  logic [31:0] word_mosi, word_miso, word_dur;

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit finished = 0;
  int w_cnt = 0, w_cyc = 0, e_cnt = 0, e_cyc = 0;
  logic [31:0] w_mo, w_mi, w_dur;
  logic w_err, e_old, e_new;

  always #5 clk = ~clk;

  spi_sniffer u0 (
    .clk_i(clk), .rst_ni(rst_n), .sck_i(sck), .mosi_i(mosi), .miso_i(miso), .cs_i(cs),
    .cpol_i(cpol), .cpha_i(cpha), .lsb_first_i(lsb), .word_len_i(wlen),
    .cs_act_high_i(cs_ah), .cs_en_i(cs_en),
    .word_valid_o(word_valid), .word_mosi_o(word_mosi), .word_miso_o(word_miso),
    .word_dur_o(word_dur), .word_err_o(word_err),
    .cs_evt_valid_o(evt_valid), .cs_evt_old_o(evt_old), .cs_evt_new_o(evt_new)
  );

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (word_valid) begin
      w_cnt <= w_cnt + 1; w_cyc <= cyc;
      w_mo <= word_mosi; w_mi <= word_miso; w_dur <= word_dur; w_err <= word_err;
    end
    if (evt_valid) begin
      e_cnt <= e_cnt + 1; e_cyc <= cyc; e_old <= evt_old; e_new <= evt_new;
    end
  end

  localparam int NV = 6;
  localparam int V_CPOL [NV] = '{0, 0, 1, 1, 0, 1};
  localparam int V_CPHA [NV] = '{0, 1, 0, 1, 0, 1};
  localparam int V_LSB  [NV] = '{0, 1, 0, 1, 1, 0};
  localparam int V_LEN  [NV] = '{8, 8, 12, 5, 32, 1};
  localparam int V_H    [NV] = '{2, 3, 2, 4, 2, 3};
  localparam logic [31:0] V_MO [NV] = '{32'hA5, 32'h1E, 32'hABC, 32'h13, 32'hDEADBEEF, 32'h1};
  localparam logic [31:0] V_MI [NV] = '{32'h3C, 32'hC7, 32'h5A3, 32'h0A, 32'h12345678, 32'h0};

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bit_out(input logic bm, input logic bi, input int h);
    if (!cpha) begin
      mosi = bm; miso = bi; wt(h); sck = ~cpol; wt(h); sck = cpol;
    end else begin
      sck = ~cpol; mosi = bm; miso = bi; wt(h); sck = cpol; wt(h);
    end
  endtask

  task automatic send_bits(input int n, input logic [31:0] mo, input logic [31:0] mi, input int h);
    for (int k = 0; k < n; k++)
      bit_out(lsb ? mo[k] : mo[n-1-k], lsb ? mi[k] : mi[n-1-k], h);
  endtask

  task automatic frame_open(input logic cp, input logic ph);
    cs = 1'b1; wt(4);
    cpol = cp; cpha = ph; sck = cp; wt(4);
    cs = 1'b0; wt(4);
  endtask

  task automatic frame_close();
    wt(6); cs = 1'b1; wt(6);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog act=hung exp=done");
    finish_run();
  end

  initial begin
    int w0, e0, t;
    wt(3); rst_n = 1'b1; wt(8);
    // R11 reset state and no event from idle lines
    chk("R11 word_valid after reset", word_valid, 0);
    chk("R11 evt_valid after reset", evt_valid, 0);
    chk("R11 no event after reset", e_cnt, 0);
    chk("R11 no word after reset", w_cnt, 0);

    // table: R1 modes, R2 both lines, R3 order, R4 lengths, R8 duration
    for (int v = 0; v < NV; v++) begin
      lsb = V_LSB[v][0]; wlen = 6'(V_LEN[v]);
      frame_open(V_CPOL[v][0], V_CPHA[v][0]);
      w0 = w_cnt;
      send_bits(V_LEN[v], V_MO[v], V_MI[v], V_H[v]);
      wt(6);
      chk("R2 one record per word", w_cnt, w0 + 1);
      chk("R1/R3 mosi word", w_mo, V_MO[v]);
      chk("R2/R3 miso word", w_mi, V_MI[v]);
      chk("R8 duration", w_dur, (V_LEN[v] - 1) * 2 * V_H[v] + 1);
      chk("R7 err clear", w_err, 0);
      frame_close();
    end

    // R11 latency and R5 event content
    lsb = 0; wlen = 6'd1;
    frame_open(0, 0);
    w0 = w_cnt;
    mosi = 1'b1; miso = 1'b0; wt(2);
    sck = 1'b1; t = cyc; wt(6);
    chk("R11 word latency", w_cyc, t + 3);
    chk("R11 word count", w_cnt, w0 + 1);
    sck = 1'b0; wt(4);
    e0 = e_cnt;
    cs = 1'b1; t = cyc; wt(6);
    chk("R11 event latency", e_cyc, t + 3);
    chk("R5 event count", e_cnt, e0 + 1);
    chk("R5 event old", e_old, 0);
    chk("R5 event new", e_new, 1);

    // R6 partial word discarded on chip-select change
    wlen = 6'd8;
    frame_open(0, 0);
    send_bits(3, 32'h7, 32'h7, 2);
    e0 = e_cnt; w0 = w_cnt;
    cs = 1'b1; wt(4); cs = 1'b0; wt(4);
    chk("R6 two events", e_cnt, e0 + 2);
    chk("R6 no word from partial", w_cnt, w0);
    send_bits(8, 32'h5A, 32'hC3, 2); wt(6);
    chk("R6 count after restart", w_cnt, w0 + 1);
    chk("R6 mosi after restart", w_mo, 32'h5A);
    chk("R6 miso after restart", w_mi, 32'hC3);

    // R4 back-to-back words without chip-select toggle
    wlen = 6'd3; w0 = w_cnt;
    send_bits(3, 32'h5, 32'h2, 2);
    send_bits(3, 32'h3, 32'h6, 2); wt(6);
    chk("R4 two short words", w_cnt, w0 + 2);
    chk("R4 second mosi", w_mo, 32'h3);
    chk("R4 second miso", w_mi, 32'h6);
    frame_close();

    // R4 length 0 means 32
    wlen = 6'd0; lsb = 1'b0;
    frame_open(0, 0);
    w0 = w_cnt;
    send_bits(32, 32'hF00DCAFE, 32'h0F1E2D3C, 2); wt(6);
    chk("R4 len0 count", w_cnt, w0 + 1);
    chk("R4 len0 mosi", w_mo, 32'hF00DCAFE);
    frame_close();

    // R7 word with chip-select inactive sets err, next word clears it
    wlen = 6'd8;
    frame_open(0, 0);
    cs = 1'b1; wt(4);
    send_bits(8, 32'h96, 32'h69, 2); wt(6);
    chk("R7 err when inactive", w_err, 1);
    chk("R7 data still captured", w_mo, 32'h96);
    cs = 1'b0; wt(4);
    send_bits(8, 32'h11, 32'h22, 2); wt(6);
    chk("R7 err clears next word", w_err, 0);
    frame_close();

    // R5 active-high polarity
    cs_ah = 1'b1;
    frame_open(0, 0);
    send_bits(8, 32'h42, 32'h24, 2); wt(6);
    chk("R5 active-high low level flags err", w_err, 1);
    cs = 1'b1; wt(4);
    send_bits(8, 32'h42, 32'h24, 2); wt(6);
    chk("R5 active-high high level ok", w_err, 0);
    cs_ah = 1'b0; cs = 1'b0; wt(6);

    // R9 chip-select disabled
    cs_en = 1'b0; e0 = e_cnt;
    cs = 1'b1; wt(5); cs = 1'b0; wt(5); cs = 1'b1; wt(5);
    chk("R9 no events when disabled", e_cnt, e0);
    send_bits(8, 32'hE7, 32'h18, 2); wt(6);
    chk("R9 no err when disabled", w_err, 0);
    chk("R9 data when disabled", w_mo, 32'hE7);
    cs_en = 1'b1; cs = 1'b1; wt(6);

    // R10 coincident event and word: event first, word one cycle later
    wlen = 6'd1;
    frame_open(0, 0);
    mosi = 1'b1; miso = 1'b1; wt(2);
    e0 = e_cnt; w0 = w_cnt;
    cs = 1'b1; sck = 1'b1; t = cyc; wt(8);
    chk("R10 event cycle", e_cyc, t + 3);
    chk("R10 word cycle", w_cyc, t + 4);
    chk("R10 event count", e_cnt, e0 + 1);
    chk("R10 word count", w_cnt, w0 + 1);
    chk("R10/R6 word mosi", w_mo, 32'h1);
    chk("R10/R7 word err", w_err, 1);
    sck = 1'b0; wt(6);

    finish_run();
  end
endmodule